// File: doc/BRIEF.md
# Parameter Target Slew Ramp Engine

This block keeps a bank of parameter slots for an audio datapath. Every slot holds the value the datapath applies now, the value a host wants, a per-slot rate and a curve selection. A host write changes only the wanted value. The block then moves the applied value toward it, one step per sample tick, so a gain or coefficient change never jumps and never clicks.

A sample tick starts one pass over the bank. The pass visits the slots one per clock cycle, from the lowest index to the highest, and updates each slot through a single shared step unit. In linear curve mode a slot moves by a fixed amount each pass. In logarithmic mode it closes a binary fraction of its remaining distance. The datapath reads any slot's applied value through a combinational read port. A per-slot flag reports that a slot has arrived at its wanted value.

Top module: `param_ramp_bank`

## Requirements
- R1: After reset every slot has applied value 0 and wanted value 0, every arrival flag is 1, and `busy` is 0.
- R2: With `wr_en` high at a clock edge, slot `wr_addr` takes `wr_target`, `wr_rate` and `wr_curve` (0 = linear, 1 = logarithmic). Its arrival flag clears and its applied value does not change at that edge.
- R3: A `tick` sampled while `busy` is 0 raises `busy` for exactly 64 cycles. In that time slot k is updated at the (k+1)-th edge after the tick edge, in ascending index order.
- R4: A `tick` sampled while `busy` is 1 has no effect, and no extra pass follows.
- R5: In linear mode an update moves the applied value by `wr_rate` (an unsigned magnitude) toward the wanted value. When the remaining distance is at most that magnitude, the value becomes the wanted value and never passes it.
- R6: In logarithmic mode an update adds sign(d) * (|d| >> s), where d is the wanted value minus the applied value and s = `wr_rate[3:0]`. When that shifted magnitude is 0 or s is 0, the value becomes the wanted value.
- R7: After an update, the slot's arrival flag is 1 exactly when the new applied value equals the wanted value.
- R8: `rd_value` shows, in the same cycle, the 28-bit signed 5.23 applied value of slot `rd_addr`.
- R9: In linear mode with a rate of 0 the applied value never moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample tick, starts a pass when idle |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 6 | Slot index written |
| wr_target | input | 28 | New wanted value, signed 5.23 |
| wr_rate | input | 28 | Linear step magnitude, or shift in bits [3:0] |
| wr_curve | input | 1 | 0 linear, 1 logarithmic |
| rd_addr | input | 6 | Slot index read |
| rd_value | output | 28 | Applied value of slot rd_addr |
| busy | output | 1 | A pass is in progress |
| done_flags | output | 64 | Per-slot arrival flags |

## Verification
Ports alone cannot show the moment inside a pass at which one given slot is updated. The stimulus handles this by writing two adjacent high-index slots and reading them back at the exact cycles around the predicted update edge. A second hard case is a tick that lands in the middle of a running pass. The bench creates one by pulsing the tick a known number of cycles after the first. It then confirms that the slot moved only once and that `busy` stays low long after the pass ends.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  localparam int unsigned SLOT_CNT = 64;
  localparam int unsigned VAL_W    = 28;
  localparam int unsigned SHIFT_W  = 4;

  typedef enum logic {
    CURVE_LIN = 1'b0,
    CURVE_LOG = 1'b1
  } curve_e;
endpackage

// File: rtl/ramp_seq.sv
module ramp_seq #(
  parameter int unsigned N_SLOTS = 64,
  localparam int unsigned AW = $clog2(N_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic          busy,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(N_SLOTS - 1);

  logic          busy_d;
  logic [AW-1:0] idx_d;

  always_comb begin
    busy_d = busy;
    idx_d  = idx;
    if (!busy) begin
      if (tick) begin
        busy_d = 1'b1;
        idx_d  = '0;
      end
    end else if (idx == LAST) begin
      busy_d = 1'b0;
    end else begin
      idx_d = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      busy <= busy_d;
      idx  <= idx_d;
    end
  end
endmodule

// File: rtl/ramp_step.sv
module ramp_step
  import ramp_pkg::*;
#(
  parameter int unsigned W = 28
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] tgt,
  input  logic [W-1:0] rate,
  input  curve_e       curve,
  output logic [W-1:0] nxt
);
  logic signed [W:0] diff;
  logic        [W:0] mag;
  logic        [W:0] inc;
  logic        [W:0] cur_x;
  logic        [W:0] sum;
  logic              neg;
  logic              snap;
  logic [SHIFT_W-1:0] sh;

  always_comb begin
    cur_x = {cur[W-1], cur};
    diff  = $signed({tgt[W-1], tgt}) - $signed(cur_x);
    neg   = diff[W];
    mag   = neg ? (~diff + 1'b1) : diff;
    sh    = rate[SHIFT_W-1:0];
    if (curve == CURVE_LIN) begin
      inc  = {1'b0, rate};
      snap = (mag <= inc);
    end else begin
      inc  = mag >> sh;
      snap = (inc == '0) || (sh == '0);
    end
    sum = neg ? (cur_x - inc) : (cur_x + inc);
    nxt = snap ? tgt : sum[W-1:0];
  end
endmodule

// File: rtl/param_ramp_bank.sv
module param_ramp_bank
  import ramp_pkg::*;
#(
  parameter int unsigned N_SLOTS = SLOT_CNT,
  parameter int unsigned W       = VAL_W,
  localparam int unsigned AW     = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [W-1:0]       wr_target,
  input  logic [W-1:0]       wr_rate,
  input  logic               wr_curve,
  input  logic [AW-1:0]      rd_addr,
  output logic [W-1:0]       rd_value,
  output logic               busy,
  output logic [N_SLOTS-1:0] done_flags
);
  logic          rst_meta_n;
  logic          rst_sync_n;
  logic [AW-1:0] idx;
  logic          upd_en;
  logic [W-1:0]  sel_cur;
  logic [W-1:0]  sel_tgt;
  logic [W-1:0]  step_nxt;
  curve_e        sel_curve;

  logic [W-1:0]  cur_q   [N_SLOTS];
  logic [W-1:0]  tgt_q   [N_SLOTS];
  logic [W-1:0]  rate_q  [N_SLOTS];
  curve_e        curve_q [N_SLOTS];
  logic [W-1:0]  sel_rate;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ramp_seq #(.N_SLOTS(N_SLOTS)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick),
    .busy  (busy),
    .idx   (idx)
  );

  assign upd_en    = busy;
  assign sel_cur   = cur_q[idx];
  assign sel_tgt   = tgt_q[idx];
  assign sel_rate  = rate_q[idx];
  assign sel_curve = curve_q[idx];

  ramp_step #(.W(W)) u_step (
    .cur   (sel_cur),
    .tgt   (sel_tgt),
    .rate  (sel_rate),
    .curve (sel_curve),
    .nxt   (step_nxt)
  );

  generate
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      logic wr_hit;
      logic up_hit;
      assign wr_hit = wr_en && (wr_addr == AW'(i));
      assign up_hit = upd_en && (idx == AW'(i));

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          cur_q[i]      <= '0;
          tgt_q[i]      <= '0;
          rate_q[i]     <= '0;
          curve_q[i]    <= CURVE_LIN;
          done_flags[i] <= 1'b1;
        end else begin
          if (up_hit) cur_q[i] <= step_nxt;
          if (wr_hit) begin
            tgt_q[i]   <= wr_target;
            rate_q[i]  <= wr_rate;
            curve_q[i] <= curve_e'(wr_curve);
          end
          if (wr_hit)      done_flags[i] <= 1'b0;
          else if (up_hit) done_flags[i] <= (step_nxt == sel_tgt);
        end
      end
    end
  endgenerate

  assign rd_value = cur_q[rd_addr];
endmodule

// File: rtl/ramp_bank_chk.sv
module ramp_bank_chk #(
  parameter int unsigned N_SLOTS = 64,
  parameter int unsigned W       = 28,
  localparam int unsigned AW     = $clog2(N_SLOTS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               busy,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [N_SLOTS-1:0] done_flags,
  input logic [AW-1:0]      idx,
  input logic               upd_en,
  input logic [W-1:0]       sel_cur,
  input logic [W-1:0]       sel_tgt,
  input logic [W-1:0]       step_nxt
);
  localparam logic [AW-1:0] LAST = AW'(N_SLOTS - 1);

  logic signed [W-1:0] c_s, t_s, n_s;
  assign c_s = sel_cur;
  assign t_s = sel_tgt;
  assign n_s = step_nxt;

  AST_PASS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tick) |=> busy);  // R3

  AST_PASS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));  // R3

  AST_PASS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == LAST) |=> !busy);  // R4

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> ((t_s >= c_s) ? (n_s >= c_s && n_s <= t_s)
                             : (n_s <= c_s && n_s >= t_s)));  // R5

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !done_flags[$past(wr_addr)]);  // R2
endmodule

bind param_ramp_bank ramp_bank_chk #(.N_SLOTS(N_SLOTS), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .busy       (busy),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .done_flags (done_flags),
  .idx        (idx),
  .upd_en     (upd_en),
  .sel_cur    (sel_cur),
  .sel_tgt    (sel_tgt),
  .step_nxt   (step_nxt)
);

// File: tb/test_param_ramp_bank.sv
module test_param_ramp_bank;
  localparam int N = 64;
  localparam int W = 28;

  logic          clk;
  logic          rst_n;
  logic          tick;
  logic          wr_en;
  logic [5:0]    wr_addr;
  logic [W-1:0]  wr_target;
  logic [W-1:0]  wr_rate;
  logic          wr_curve;
  logic [5:0]    rd_addr;
  logic [W-1:0]  rd_value;
  logic          busy;
  logic [N-1:0]  done_flags;

  int checks;
  int failures;

  param_ramp_bank i_param_ramp_bank (
    .clk, .rst_n, .tick, .wr_en, .wr_addr, .wr_target, .wr_rate,
    .wr_curve, .rd_addr, .rd_value, .busy, .done_flags
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {slot, target, rate, curve, passes, expected value, expected flag}
  localparam int VW = 6 + 28 + 28 + 1 + 4 + 28 + 1;
  localparam logic [VW-1:0] VEC [8] = '{
    {6'd1,  28'd1000,      28'd300,       1'b0, 4'd4, 28'd1000,      1'b1},  // R5 clamp
    {6'd2,  28'hFFFFE0C,   28'd200,       1'b0, 4'd2, 28'hFFFFE70,   1'b0},  // R5 down
    {6'd5,  28'd1024,      28'd1,         1'b1, 4'd2, 28'd768,       1'b0},  // R6
    {6'd6,  28'hFFFFC00,   28'd2,         1'b1, 4'd1, 28'hFFFFF00,   1'b0},  // R6 negative
    {6'd63, 28'd8,         28'd3,         1'b1, 4'd2, 28'd8,         1'b1},  // R6 snap
    {6'd0,  28'h7FFFFFF,   28'h4000000,   1'b0, 4'd2, 28'h7FFFFFF,   1'b1},  // R5 full scale
    {6'd10, 28'd100,       28'd0,         1'b1, 4'd1, 28'd100,       1'b1},  // R6 shift 0
    {6'd20, 28'd50,        28'd0,         1'b0, 4'd3, 28'd0,         1'b0}   // R9
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [5:0] a, input logic [W-1:0] t,
                            input logic [W-1:0] r, input logic c);
    wr_en = 1'b1; wr_addr = a; wr_target = t; wr_rate = r; wr_curve = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_pass();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (64) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0;
    wr_target = '0; wr_rate = '0; wr_curve = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_addr = 6'd17;
    #0.1;
    check("R1 value", 64'(rd_value), 64'd0);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 flags", 64'(done_flags), {64{1'b1}});

    for (int v = 0; v < 8; v++) begin
      logic [5:0] a;
      logic [W-1:0] t, r, e;
      logic c, ed;
      logic [3:0] n;
      {a, t, r, c, n, e, ed} = VEC[v];
      host_write(a, t, r, c);
      rd_addr = a;
      #0.1;
      check("R2 value held at write", 64'(rd_value), 64'd0);
      check("R2 flag cleared", 64'(done_flags[a]), 64'd0);
      for (int k = 0; k < int'(n); k++) run_pass();
      check("R5 R6 R9 value", 64'(rd_value), 64'(e));
      check("R7 flag", 64'(done_flags[a]), 64'(ed));
    end

    // R2: rewrite an arrived slot with the same target clears its flag
    host_write(6'd1, 28'd1000, 28'd300, 1'b0);
    rd_addr = 6'd1;
    check("R2 rewrite flag", 64'(done_flags[1]), 64'd0);
    check("R8 value kept", 64'(rd_value), 64'd1000);

    // R3 busy window and slot order
    host_write(6'd40, 28'd100, 28'd10, 1'b0);
    host_write(6'd41, 28'd100, 28'd10, 1'b0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R3 busy rises", 64'(busy), 64'd1);
    repeat (40) @(negedge clk);
    rd_addr = 6'd40;
    #0.1;
    check("R3 slot 40 not yet", 64'(rd_value), 64'd0);
    @(negedge clk);
    check("R3 slot 40 updated", 64'(rd_value), 64'd10);
    rd_addr = 6'd41;
    #0.1;
    check("R3 slot 41 not yet", 64'(rd_value), 64'd0);
    @(negedge clk);
    check("R3 slot 41 updated", 64'(rd_value), 64'd10);
    repeat (21) @(negedge clk);
    check("R3 busy at cycle 64", 64'(busy), 64'd1);
    @(negedge clk);
    check("R3 busy falls", 64'(busy), 64'd0);

    // R4 tick during a pass is ignored
    host_write(6'd30, 28'd1000, 28'd10, 1'b0);
    rd_addr = 6'd30;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (10) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (53) @(negedge clk);
    check("R4 busy ends on time", 64'(busy), 64'd0);
    repeat (70) @(negedge clk);
    check("R4 single step", 64'(rd_value), 64'd10);
    check("R4 no extra pass", 64'(busy), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule